// File: doc/BRIEF.md
# Ping-Pong Result Bank Writer

This block sits between a matrix decomposition engine and a host processor. The engine streams 32-bit result words into one of two memory banks, even and odd. A host reads the other bank at the same time. When a result set is complete, the two banks swap roles. The host then sees the freshly finished set, and the engine starts filling the bank the host has just let go.

Each bank owns an address multiplexer. While the bank is the write target it follows the write address counter. Otherwise it follows the read address counter. The write counter wraps after a fixed number of words per set. The engine can also end a set early by raising its done signal with the last word. The wrap is registered, and that registered terminal count is the single event that swaps the banks. It also clears the read counter and raises a per-bank result-ready interrupt. That interrupt stays set until the host acknowledges it. A completion that arrives while any interrupt is still pending sets a sticky overrun flag.

Top module: `pp_result_banks`

## Requirements
- R1: After reset, `irq` is 2'b00, `overrun` is 0, writes target the even bank (bank 0), and `host_bank` is 1 (the odd bank is the read side).
- R2: A result set completes on the write that lands at address SET_WORDS-1. `irq` bit of the finished bank does not change in the cycle after that write, and is set one cycle later.
- R3: Successive result sets alternate banks: even, odd, even, and so on. `irq[0]` flags the even bank and `irq[1]` the odd bank.
- R4: Each `host_rd` strobe returns, on `host_rd_data` one cycle later, the next word of the most recently completed bank, starting at address 0.
- R5: Writes to the write-side bank never change the words the host reads from the read-side bank.
- R6: A write strobe that carries `eng_done` ends the set early. The next set starts again at address 0 in the other bank.
- R7: An `irq` bit stays set until its own `host_ack` bit is pulsed, and an acknowledge clears only that bit.
- R8: A completion while any `irq` bit is set raises `overrun`, which then stays set until reset.
- R9: The read address wraps to 0 after SET_WORDS reads and is cleared to 0 on every completion.
- R10: `host_bank` changes only in the cycle right after the final write of a set, never during a write burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_data | input | 32 | Result word from the engine |
| res_wr | input | 1 | Result write strobe |
| eng_done | input | 1 | Marks the current write as the last of its set |
| host_rd | input | 1 | Host read strobe; advances the read address |
| host_ack | input | 2 | Per-bank interrupt acknowledge (bit 0 even, bit 1 odd) |
| host_rd_data | output | 32 | Read data, valid one cycle after `host_rd` |
| host_bank | output | 1 | Bank currently on the host side (0 even, 1 odd) |
| irq | output | 2 | Per-bank result-ready flags |
| overrun | output | 1 | Sticky flag: completion while a flag was pending |

## Verification
The hardest case to reach is a completion that lands while an earlier interrupt is still unacknowledged. It needs a partial read in progress, so the completion must clear the read address mid-stream.

The stimulus reaches it in several steps. First it reads part of an early-terminated set and leaves that set's flag pending. Then it writes a full set into the other bank. The overrun flag, both interrupt bits and a following read that must come from address 0 of the new set are then checked together.

A concurrent phase also interleaves host reads of one set with a partial write of the next. This shows that the address multiplexers keep the two sides apart.

// File: rtl/pp_bank_pkg.sv
package pp_bank_pkg;

  localparam int unsigned NUM_BANKS = 2;

  typedef enum logic {
    BANK_EVEN = 1'b0,
    BANK_ODD  = 1'b1
  } bank_e;

endpackage

// File: rtl/pp_addr_ctr.sv
// Wrapping address counter with an early-cut input and a synchronous clear.
module pp_addr_ctr #(
  parameter int unsigned AW    = 6,
  parameter int unsigned LIMIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          cut,
  input  logic          clr,
  output logic [AW-1:0] cnt,
  output logic          wrap
);

  localparam logic [AW-1:0] LAST = AW'(LIMIT - 1);

  logic [AW-1:0] cnt_q;
  logic [AW-1:0] cnt_d;
  logic          cnt_en;

  assign wrap   = step && ((cnt_q == LAST) || cut);
  assign cnt_en = clr || step;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || wrap) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = cnt_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pp_bank_ram.sv
// Single-port bank, registered read, write has priority over read.
module pp_bank_ram #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    if (re && !we) begin
      rdata_q <= mem[addr];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/pp_done_flags.sv
// Per-bank result-ready flags with acknowledge and a sticky overrun.
module pp_done_flags
  import pp_bank_pkg::*;
#(
  parameter int unsigned NB = NUM_BANKS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_pulse,
  input  bank_e         done_bank,
  input  logic [NB-1:0] ack,
  output logic [NB-1:0] irq,
  output logic          overrun
);

  logic [NB-1:0] irq_q;
  logic [NB-1:0] irq_d;
  logic          ovr_q;
  logic          ovr_d;

  for (genvar b = 0; b < NB; b++) begin : g_flag
    logic set_b;
    assign set_b = done_pulse && (done_bank == bank_e'(b));
    always_comb begin
      irq_d[b] = set_b || (irq_q[b] && !ack[b]);
    end
  end

  always_comb begin
    ovr_d = ovr_q || (done_pulse && (irq_q != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      ovr_q <= ovr_d;
    end
  end

  assign irq     = irq_q;
  assign overrun = ovr_q;

endmodule

// File: rtl/pp_result_banks.sv
module pp_result_banks
  import pp_bank_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned SET_WORDS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    res_data,
  input  logic                 res_wr,
  input  logic                 eng_done,
  input  logic                 host_rd,
  input  logic [NUM_BANKS-1:0] host_ack,
  output logic [DATA_W-1:0]    host_rd_data,
  output logic                 host_bank,
  output logic [NUM_BANKS-1:0] irq,
  output logic                 overrun
);

  localparam int unsigned NB = NUM_BANKS;

  // Bank roles
  bank_e wr_bank_q;
  bank_e wr_bank_d;
  bank_e wr_sel;
  bank_e rd_sel;
  bank_e rd_sel_q;
  logic  tc_q;

  logic [ADDR_W-1:0] wr_cnt;
  logic [ADDR_W-1:0] rd_cnt;
  logic              wr_wrap;
  logic              rd_wrap;

  logic [ADDR_W-1:0] bank_addr  [NB];
  logic [DATA_W-1:0] bank_rdata [NB];
  logic [NB-1:0]     bank_we;
  logic [NB-1:0]     bank_re;

  // The registered terminal count hands the finished bank to the host
  // in the same cycle the engine moves on to the other one.
  assign wr_sel    = bank_e'(wr_bank_q ^ tc_q);
  assign rd_sel    = bank_e'(~wr_sel);
  assign wr_bank_d = tc_q ? bank_e'(~wr_bank_q) : wr_bank_q;

  pp_addr_ctr #(.AW(ADDR_W), .LIMIT(SET_WORDS)) u_wr_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (res_wr),
    .cut   (eng_done),
    .clr   (1'b0),
    .cnt   (wr_cnt),
    .wrap  (wr_wrap)
  );

  pp_addr_ctr #(.AW(ADDR_W), .LIMIT(SET_WORDS)) u_rd_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (host_rd),
    .cut   (1'b0),
    .clr   (tc_q),
    .cnt   (rd_cnt),
    .wrap  (rd_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bank_q <= BANK_EVEN;
      tc_q      <= 1'b0;
    end else begin
      wr_bank_q <= wr_bank_d;
      tc_q      <= wr_wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sel_q <= BANK_ODD;
    end else if (host_rd) begin
      rd_sel_q <= rd_sel;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic is_wr;
    assign is_wr        = (wr_sel == bank_e'(b));
    assign bank_addr[b] = is_wr ? wr_cnt : rd_cnt;
    assign bank_we[b]   = res_wr && is_wr;
    assign bank_re[b]   = host_rd && !is_wr;

    pp_bank_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
      .clk   (clk),
      .we    (bank_we[b]),
      .re    (bank_re[b]),
      .addr  (bank_addr[b]),
      .wdata (res_data),
      .rdata (bank_rdata[b])
    );
  end

  pp_done_flags #(.NB(NB)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_pulse (tc_q),
    .done_bank  (wr_bank_q),
    .ack        (host_ack),
    .irq        (irq),
    .overrun    (overrun)
  );

  assign host_rd_data = bank_rdata[rd_sel_q];
  assign host_bank    = rd_sel;

  // rd_wrap only signals a wrap; the counter already handles it.
  logic unused_rd_wrap;
  assign unused_rd_wrap = rd_wrap;

endmodule

// File: rtl/pp_result_banks_chk.sv
module pp_result_banks_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       res_wr,
  input logic [1:0] host_ack,
  input logic [1:0] irq,
  input logic       overrun,
  input logic       host_bank,
  input logic       tc_q
);

  // R7: a pending flag holds until its own acknowledge
  p_irq_hold_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[0] && !host_ack[0]) |=> irq[0]);
  p_irq_hold_odd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[1] && !host_ack[1]) |=> irq[1]);

  // R7: an acknowledge without a coinciding completion clears the flag
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack[0] && !tc_q) |=> !irq[0]);

  // R2: a flag only rises after a registered terminal count
  p_irq_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~$past(irq)) != 2'b00) |-> $past(tc_q));

  // R8: overrun is sticky and only caused by completion on a pending flag
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  p_overrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(tc_q) && ($past(irq) != 2'b00)));

  // R10: the host side swaps only right after a final write
  p_bank_switch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_bank != $past(host_bank)) |-> ($past(res_wr) && tc_q));

endmodule

bind pp_result_banks pp_result_banks_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_wr    (res_wr),
  .host_ack  (host_ack),
  .irq       (irq),
  .overrun   (overrun),
  .host_bank (host_bank),
  .tc_q      (tc_q)
);

// File: tb/pp_result_banks_tb.sv
`timescale 1ns/1ps
module pp_result_banks_tb;

  localparam int unsigned DW  = 32;
  localparam int unsigned LEN = 16;

  logic          clk;
  logic          rst_n;
  logic [DW-1:0] res_data;
  logic          res_wr;
  logic          eng_done;
  logic          host_rd;
  logic [1:0]    host_ack;
  logic [DW-1:0] host_rd_data;
  logic          host_bank;
  logic [1:0]    irq;
  logic          overrun;

  pp_result_banks u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_data     (res_data),
    .res_wr       (res_wr),
    .eng_done     (eng_done),
    .host_rd      (host_rd),
    .host_ack     (host_ack),
    .host_rd_data (host_rd_data),
    .host_bank    (host_bank),
    .irq          (irq),
    .overrun      (overrun)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  // Reference model built from the requirements
  logic [DW-1:0] mdl [2][64];
  int mwb   = 0;
  int mrd   = 1;
  int mwptr = 0;
  int rptr  = 0;

  // Scoreboard
  logic [DW-1:0] exp_d [$];
  string         exp_t [$];
  logic          rd_seen;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_seen <= 1'b0;
    else        rd_seen <= host_rd;
  end

  // Monitor: compares returned read data against queued expectations
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_d.size() == 0) begin
        chk("R4 unexpected", 64'(host_rd_data), 64'hDEAD);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_d.pop_front();
        t = exp_t.pop_front();
        chk(t, 64'(host_rd_data), 64'(e));
      end
    end
  end

  // Driver: writes n words; R10 checks the host side stays put during the burst
  task automatic write_words(int n, bit done_last, logic [DW-1:0] base);
    logic hb0;
    hb0 = host_bank;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) chk("R10", 64'(host_bank), 64'(hb0));
      res_wr   = 1'b1;
      res_data = base + DW'(i);
      eng_done = done_last && (i == n - 1);
      mdl[mwb][mwptr] = base + DW'(i);
      mwptr++;
      if (mwptr == LEN || eng_done) begin
        mrd   = mwb;
        mwb   = 1 - mwb;
        mwptr = 0;
        rptr  = 0;
      end
    end
    @(negedge clk);
    res_wr   = 1'b0;
    eng_done = 1'b0;
  endtask

  task automatic host_read(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      host_rd = 1'b1;
      exp_d.push_back(mdl[mrd][rptr]);
      exp_t.push_back(tag);
      rptr = (rptr + 1) % LEN;
    end
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic ack(logic [1:0] bits);
    @(negedge clk);
    host_ack = bits;
    @(negedge clk);
    host_ack = 2'b00;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; res_data = '0; res_wr = 1'b0; eng_done = 1'b0;
    host_rd = 1'b0; host_ack = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 irq", 64'(irq), 64'(2'b00));
    chk("R1 overrun", 64'(overrun), 64'(1'b0));
    chk("R1 host_bank", 64'(host_bank), 64'(1'b1));

    // R2: full set into even bank
    write_words(LEN, 1'b0, 32'hA000_0000);
    chk("R10 swap", 64'(host_bank), 64'(1'b0));
    chk("R2 not yet", 64'(irq), 64'(2'b00));
    @(negedge clk);
    chk("R2 irq", 64'(irq), 64'(2'b01));
    repeat (3) @(negedge clk);
    chk("R7 held", 64'(irq), 64'(2'b01));

    // R5: read set A while partly writing set B into the odd bank
    fork
      host_read(LEN, "R5");
      write_words(10, 1'b0, 32'hB000_0000);
    join
    ack(2'b01);
    chk("R7 ack", 64'(irq), 64'(2'b00));

    // R3: finish set B in the odd bank
    write_words(LEN - 10, 1'b0, 32'hB000_000A);
    @(negedge clk);
    chk("R3 irq", 64'(irq), 64'(2'b10));
    chk("R3 host_bank", 64'(host_bank), 64'(1'b1));
    chk("R8 no overrun", 64'(overrun), 64'(1'b0));
    host_read(LEN, "R4");
    host_read(3, "R9 wrap");
    ack(2'b10);

    // R6: early end of set via eng_done
    write_words(5, 1'b1, 32'hC000_0000);
    @(negedge clk);
    chk("R6 irq", 64'(irq), 64'(2'b01));
    chk("R6 host_bank", 64'(host_bank), 64'(1'b0));
    host_read(6, "R6");

    // R8: completion while even flag still pending
    write_words(LEN, 1'b0, 32'hD000_0000);
    @(negedge clk);
    chk("R8 overrun", 64'(overrun), 64'(1'b1));
    chk("R8 irq", 64'(irq), 64'(2'b11));
    host_read(1, "R9 restart");
    ack(2'b10);
    chk("R7 selective", 64'(irq), 64'(2'b01));
    ack(2'b01);
    chk("R7 cleared", 64'(irq), 64'(2'b00));
    chk("R8 sticky", 64'(overrun), 64'(1'b1));

    repeat (3) @(negedge clk);
    chk("R4 drained", 64'(exp_d.size()), 64'd0);
    finish_run();
  end

endmodule